// File: doc/BRIEF.md
# Routed Configuration Distributor

This block is the register-side control logic of a multi-master serial ADC front end. Software writes one shared 32-bit value register, picks the targets with two one-hot masks (one over the serial masters, one over the channels of each master), and says what the value means with a three-bit selector field in the control register. Setting the value-valid bit starts a transfer. The block holds the transfer until none of the selected masters is busy, then emits a single-cycle configuration strobe carrying the kind, both masks and the value. It then clears value-valid, and software polls that bit as its acknowledgement.

The same control register carries the sampling mode (continuous or triggered), the trigger source (software or hardware pins), a self-clearing software trigger bit and a self-clearing software reset bit. The software trigger fires all selected, available masters in one cycle, once they are idle. Per-master flags for transfer-done and processing-done clear when a master is started and set when it reports completion. A busy view and a writable availability mask complete the register set. The SPI manual-control and timing words are stored and driven out unchanged for the masters to use.

A sequencer drives the transfer and trigger handshakes. Its states are `ST_IDLE`, `ST_CFG_WAIT`, `ST_CFG_PUSH`, `ST_TRG_WAIT` and `ST_TRG_FIRE`. From `ST_IDLE` it goes to `ST_CFG_WAIT` when value-valid is set, or otherwise to `ST_TRG_WAIT` when the software trigger bit is set. `ST_CFG_WAIT` moves to `ST_CFG_PUSH` once no selected master is busy. `ST_CFG_PUSH` strobes and returns to `ST_IDLE`. `ST_TRG_WAIT` moves to `ST_TRG_FIRE` once no selected, available master is busy. `ST_TRG_FIRE` pulses the trigger and returns to `ST_IDLE`.

Top module: `cfg_router`

## Requirements
- R1: After reset, control reads 0, both select masks and the value read 0, the SPI timing word reads 0, the SPI manual word drives 0x40, availability reads all ones over the implemented masters, and no strobe or trigger is active.
- R2: The control (0x00), SPI manual (0x04), SPI timing (0x08), master select (0x0C), channel select (0x10), value (0x20) and availability (0x24) registers read back what was written. Only the implemented master and channel bits are stored; the unused upper bits read 0.
- R3: With control bit 4 (value-valid) set, exactly one configuration strobe is emitted. It carries the kind taken from control bits 6:5 (00 offset, 01 conversion factor, 10 samples per trigger, 11 sample time), together with the current master mask, channel mask and value.
- R4: While any master that is selected in the master mask reports busy, the strobe is held back and value-valid stays set. Busy masters outside the mask do not delay it.
- R5: Hardware clears value-valid in the cycle after the strobe, and this serves as the acknowledgement.
- R6: A selector with control bit 7 set (100 to 111) is reserved. Such a transfer is still acknowledged by clearing value-valid, but no strobe is emitted.
- R7: When control bit 0 (mode) is 0 and bit 1 (source) is 1, setting bit 2 (software trigger) pulses the trigger output for exactly one cycle, at the same time on every master that is both selected and available. The pulse waits until none of those masters is busy, and bit 2 then clears.
- R8: When mode is 0 and source is 0, the trigger output equals the hardware trigger pins masked by availability and by the inverse of busy, whatever the master mask holds. When source is 1, the pins have no effect. When source is 0, the software trigger bit is cleared without producing a pulse.
- R9: When mode is 1, every available master that is not busy is triggered in every cycle.
- R10: The transfer-done (0x14) and processing-done (0x18) flags of a master set on that master's finish pulse and clear when it is triggered. Writes to these registers are ignored.
- R11: Writing control with bit 3 set resets every register and flag to its reset value after a one-cycle reset pulse on `core_rst`. Bit 3 always reads 0.
- R12: The busy register (0x1C) reads the current per-master busy inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| hw_trig | input | N_MST | Hardware trigger pins, one per master |
| mst_busy | input | N_MST | Per-master busy status |
| xfer_fin | input | N_MST | Per-master transfer-finished pulse |
| proc_fin | input | N_MST | Per-master processing-finished pulse |
| trig_out | output | N_MST | Conversion start pulse per master |
| core_rst | output | 1 | One-cycle software reset pulse to the masters |
| cont_mode | output | 1 | Continuous sampling mode is selected |
| spi_manual | output | 8 | Stored SPI manual-control word |
| spi_timing | output | 32 | Stored SPI timing word |
| cfg_we | output | 1 | Configuration strobe |
| cfg_kind | output | 2 | Meaning of cfg_value |
| cfg_mst | output | N_MST | Target master mask |
| cfg_ch | output | N_CH | Target channel mask |
| cfg_value | output | 32 | Value to load into the targets |

## Verification
The bench builds the block with four masters and eight channels. With this size, unused upper mask bits are visible, and a master mask can hold selected, unselected, busy and unavailable masters at the same time. Within one trigger, it can be shown that a busy selected master holds every selected master back, and that an unavailable one is left out of the simultaneous pulse. Expected strobes are queued as kind, masks and value, and each strobe is matched in order against the queue.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

    localparam int ADDR_W = 8;
    localparam int REG_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SMAN  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STIM  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_MSEL  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_CSEL  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_XDONE = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_PDONE = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_BUSY  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_VAL   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_AVAIL = 8'h24;

    // control register bit positions
    localparam int CB_MODE = 0;
    localparam int CB_SRC  = 1;
    localparam int CB_TRG  = 2;
    localparam int CB_RST  = 3;
    localparam int CB_VLD  = 4;
    localparam int CB_SEL  = 5;

    localparam logic [7:0] SMAN_RESET = 8'h40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG_WAIT,
        ST_CFG_PUSH,
        ST_TRG_WAIT,
        ST_TRG_FIRE
    } seq_state_t;

    typedef enum logic [1:0] {
        KIND_OFFSET  = 2'd0,
        KIND_FACTOR  = 2'd1,
        KIND_SAMPLES = 2'd2,
        KIND_STIME   = 2'd3
    } cfg_kind_t;

endpackage

// File: rtl/cfg_regs.sv
module cfg_regs
    import cfg_router_pkg::*;
#(
    parameter int N_MST = 4,
    parameter int N_CH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              clr_vld,
    input  logic              clr_trg,
    input  logic [N_MST-1:0]  busy_in,
    input  logic [N_MST-1:0]  xdone,
    input  logic [N_MST-1:0]  pdone,
    output logic              core_rst,
    output logic              int_rst_n,
    output logic              mode_cont,
    output logic              src_sw,
    output logic              trg_req,
    output logic              vld,
    output logic [2:0]        sel,
    output logic [N_MST-1:0]  mst_sel,
    output logic [N_CH-1:0]   ch_sel,
    output logic [REG_W-1:0]  value,
    output logic [N_MST-1:0]  avail,
    output logic [7:0]        spi_man,
    output logic [REG_W-1:0]  spi_tim
);

    localparam int SEL_W = 3;

    logic wr_ctrl;
    logic rst_req;

    assign wr_ctrl   = bus_we && (bus_addr == OFS_CTRL);
    assign rst_req   = wr_ctrl && bus_wdata[CB_RST];
    assign int_rst_n = rst_n && !core_rst;

    // reset pulse flop, cleared only by the external reset
    always_ff @(posedge clk) begin
        if (!rst_n) core_rst <= 1'b0;
        else        core_rst <= rst_req;
    end

    // control register
    always_ff @(posedge clk) begin
        if (!int_rst_n) begin
            mode_cont <= 1'b0;
            src_sw    <= 1'b0;
            trg_req   <= 1'b0;
            vld       <= 1'b0;
            sel       <= '0;
        end else if (wr_ctrl) begin
            if (!bus_wdata[CB_RST]) begin
                mode_cont <= bus_wdata[CB_MODE];
                src_sw    <= bus_wdata[CB_SRC];
                trg_req   <= bus_wdata[CB_TRG];
                vld       <= bus_wdata[CB_VLD];
                sel       <= bus_wdata[CB_SEL +: SEL_W];
            end
        end else begin
            if (clr_vld) vld     <= 1'b0;
            if (clr_trg) trg_req <= 1'b0;
        end
    end

    // plain storage registers
    always_ff @(posedge clk) begin
        if (!int_rst_n) begin
            mst_sel <= '0;
            ch_sel  <= '0;
            value   <= '0;
            avail   <= '1;
            spi_man <= SMAN_RESET;
            spi_tim <= '0;
        end else if (bus_we) begin
            unique case (bus_addr)
                OFS_SMAN:  spi_man <= bus_wdata[7:0];
                OFS_STIM:  spi_tim <= bus_wdata;
                OFS_MSEL:  mst_sel <= bus_wdata[N_MST-1:0];
                OFS_CSEL:  ch_sel  <= bus_wdata[N_CH-1:0];
                OFS_VAL:   value   <= bus_wdata;
                OFS_AVAIL: avail   <= bus_wdata[N_MST-1:0];
                default:   ;
            endcase
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[CB_MODE]            = mode_cont;
                bus_rdata[CB_SRC]             = src_sw;
                bus_rdata[CB_TRG]             = trg_req;
                bus_rdata[CB_VLD]             = vld;
                bus_rdata[CB_SEL +: SEL_W]    = sel;
            end
            OFS_SMAN:  bus_rdata[7:0]        = spi_man;
            OFS_STIM:  bus_rdata             = spi_tim;
            OFS_MSEL:  bus_rdata[N_MST-1:0]  = mst_sel;
            OFS_CSEL:  bus_rdata[N_CH-1:0]   = ch_sel;
            OFS_XDONE: bus_rdata[N_MST-1:0]  = xdone;
            OFS_PDONE: bus_rdata[N_MST-1:0]  = pdone;
            OFS_BUSY:  bus_rdata[N_MST-1:0]  = busy_in;
            OFS_VAL:   bus_rdata             = value;
            OFS_AVAIL: bus_rdata[N_MST-1:0]  = avail;
            default:   bus_rdata             = '0;
        endcase
    end

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
    import cfg_router_pkg::*;
#(
    parameter int N_MST = 4
) (
    input  logic             clk,
    input  logic             int_rst_n,
    input  logic             vld,
    input  logic             trg_req,
    input  logic [2:0]       sel,
    input  logic [N_MST-1:0] mst_sel,
    input  logic [N_MST-1:0] avail,
    input  logic [N_MST-1:0] busy,
    output logic             cfg_we,
    output logic [1:0]       cfg_kind,
    output logic             clr_vld,
    output logic             clr_trg,
    output logic [N_MST-1:0] fire_mask
);

    seq_state_t state_q, state_d;

    logic cfg_clear;
    logic trg_clear;
    logic reserved;

    assign cfg_clear = (mst_sel & busy) == '0;
    assign trg_clear = (mst_sel & avail & busy) == '0;
    assign reserved  = sel[2];

    // state register
    always_ff @(posedge clk) begin
        if (!int_rst_n) state_q <= ST_IDLE;
        else            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (vld)          state_d = ST_CFG_WAIT;
                else if (trg_req) state_d = ST_TRG_WAIT;
            end
            ST_CFG_WAIT: if (cfg_clear) state_d = ST_CFG_PUSH;
            ST_CFG_PUSH: state_d = ST_IDLE;
            ST_TRG_WAIT: if (trg_clear) state_d = ST_TRG_FIRE;
            ST_TRG_FIRE: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cfg_we    = 1'b0;
        clr_vld   = 1'b0;
        clr_trg   = 1'b0;
        fire_mask = '0;
        cfg_kind  = sel[1:0];
        unique case (state_q)
            ST_IDLE:     ;
            ST_CFG_WAIT: ;
            ST_CFG_PUSH: begin
                cfg_we  = !reserved;
                clr_vld = 1'b1;
            end
            ST_TRG_WAIT: ;
            ST_TRG_FIRE: begin
                fire_mask = mst_sel & avail;
                clr_trg   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfg_trig.sv
module cfg_trig #(
    parameter int N_MST = 4
) (
    input  logic             mode_cont,
    input  logic             src_sw,
    input  logic [N_MST-1:0] hw_trig,
    input  logic [N_MST-1:0] avail,
    input  logic [N_MST-1:0] busy,
    input  logic [N_MST-1:0] fire_mask,
    output logic [N_MST-1:0] trig_out
);

    logic [N_MST-1:0] ready;

    assign ready = avail & ~busy;

    always_comb begin
        if (mode_cont)   trig_out = ready;
        else if (src_sw) trig_out = fire_mask;
        else             trig_out = hw_trig & ready;
    end

endmodule

// File: rtl/cfg_status.sv
module cfg_status #(
    parameter int N_MST = 4
) (
    input  logic             clk,
    input  logic             int_rst_n,
    input  logic [N_MST-1:0] start,
    input  logic [N_MST-1:0] xfer_fin,
    input  logic [N_MST-1:0] proc_fin,
    output logic [N_MST-1:0] xdone,
    output logic [N_MST-1:0] pdone
);

    for (genvar m = 0; m < N_MST; m++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!int_rst_n) begin
                xdone[m] <= 1'b0;
                pdone[m] <= 1'b0;
            end else begin
                if (start[m])         xdone[m] <= 1'b0;
                else if (xfer_fin[m]) xdone[m] <= 1'b1;
                if (start[m])         pdone[m] <= 1'b0;
                else if (proc_fin[m]) pdone[m] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfg_router.sv
module cfg_router
    import cfg_router_pkg::*;
#(
    parameter int N_MST = 4,
    parameter int N_CH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [N_MST-1:0]  hw_trig,
    input  logic [N_MST-1:0]  mst_busy,
    input  logic [N_MST-1:0]  xfer_fin,
    input  logic [N_MST-1:0]  proc_fin,
    output logic [N_MST-1:0]  trig_out,
    output logic              core_rst,
    output logic              cont_mode,
    output logic [7:0]        spi_manual,
    output logic [31:0]       spi_timing,
    output logic              cfg_we,
    output logic [1:0]        cfg_kind,
    output logic [N_MST-1:0]  cfg_mst,
    output logic [N_CH-1:0]   cfg_ch,
    output logic [31:0]       cfg_value
);

    logic             int_rst_n;
    logic             src_sw;
    logic             trg_req;
    logic             ctrl_vld;
    logic [2:0]       sel;
    logic [N_MST-1:0] avail_q;
    logic [N_MST-1:0] xdone;
    logic [N_MST-1:0] pdone;
    logic             clr_vld;
    logic             clr_trg;
    logic [N_MST-1:0] fire_mask;

    cfg_regs #(.N_MST(N_MST), .N_CH(N_CH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .clr_vld   (clr_vld),
        .clr_trg   (clr_trg),
        .busy_in   (mst_busy),
        .xdone     (xdone),
        .pdone     (pdone),
        .core_rst  (core_rst),
        .int_rst_n (int_rst_n),
        .mode_cont (cont_mode),
        .src_sw    (src_sw),
        .trg_req   (trg_req),
        .vld       (ctrl_vld),
        .sel       (sel),
        .mst_sel   (cfg_mst),
        .ch_sel    (cfg_ch),
        .value     (cfg_value),
        .avail     (avail_q),
        .spi_man   (spi_manual),
        .spi_tim   (spi_timing)
    );

    cfg_seq #(.N_MST(N_MST)) u_seq (
        .clk       (clk),
        .int_rst_n (int_rst_n),
        .vld       (ctrl_vld),
        .trg_req   (trg_req),
        .sel       (sel),
        .mst_sel   (cfg_mst),
        .avail     (avail_q),
        .busy      (mst_busy),
        .cfg_we    (cfg_we),
        .cfg_kind  (cfg_kind),
        .clr_vld   (clr_vld),
        .clr_trg   (clr_trg),
        .fire_mask (fire_mask)
    );

    cfg_trig #(.N_MST(N_MST)) u_trig (
        .mode_cont (cont_mode),
        .src_sw    (src_sw),
        .hw_trig   (hw_trig),
        .avail     (avail_q),
        .busy      (mst_busy),
        .fire_mask (fire_mask),
        .trig_out  (trig_out)
    );

    cfg_status #(.N_MST(N_MST)) u_stat (
        .clk       (clk),
        .int_rst_n (int_rst_n),
        .start     (trig_out),
        .xfer_fin  (xfer_fin),
        .proc_fin  (proc_fin),
        .xdone     (xdone),
        .pdone     (pdone)
    );

endmodule

// File: rtl/cfg_router_chk.sv
module cfg_router_chk #(
    parameter int N_MST = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [N_MST-1:0] cfg_mst,
    input logic [N_MST-1:0] mst_busy,
    input logic             ctrl_vld,
    input logic [N_MST-1:0] trig_out,
    input logic [N_MST-1:0] avail_q,
    input logic [N_MST-1:0] xdone,
    input logic [N_MST-1:0] xfer_fin,
    input logic             core_rst
);

    assert_strobe_after_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |-> ($past(cfg_mst & mst_busy) == '0));

    assert_valid_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> !ctrl_vld);

    assert_trig_only_available_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out & ~avail_q) == '0);

    assert_done_clears_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_out != '0 && xfer_fin == '0) |=> ((xdone & $past(trig_out)) == '0));

    assert_soft_reset_defaults_R11: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst |=> (avail_q == '1 && !ctrl_vld));

endmodule

bind cfg_router cfg_router_chk #(.N_MST(N_MST)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_mst  (cfg_mst),
    .mst_busy (mst_busy),
    .ctrl_vld (ctrl_vld),
    .trig_out (trig_out),
    .avail_q  (avail_q),
    .xdone    (xdone),
    .xfer_fin (xfer_fin),
    .core_rst (core_rst)
);

// File: tb/sim_cfg_router.sv
module sim_cfg_router;

    localparam int CLK_PERIOD = 10;
    localparam int M  = 4;
    localparam int C  = 8;
    localparam int IW = 2 + M + C + 32;

    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_STIM  = 8'h08;
    localparam logic [7:0] A_MSEL  = 8'h0C;
    localparam logic [7:0] A_CSEL  = 8'h10;
    localparam logic [7:0] A_XDONE = 8'h14;
    localparam logic [7:0] A_PDONE = 8'h18;
    localparam logic [7:0] A_BUSY  = 8'h1C;
    localparam logic [7:0] A_VAL   = 8'h20;
    localparam logic [7:0] A_AVAIL = 8'h24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [M-1:0]  hw_trig = '0;
    logic [M-1:0]  mst_busy = '0;
    logic [M-1:0]  xfer_fin = '0;
    logic [M-1:0]  proc_fin = '0;
    logic [M-1:0]  trig_out;
    logic          core_rst;
    logic          cont_mode;
    logic [7:0]    spi_manual;
    logic [31:0]   spi_timing;
    logic          cfg_we;
    logic [1:0]    cfg_kind;
    logic [M-1:0]  cfg_mst;
    logic [C-1:0]  cfg_ch;
    logic [31:0]   cfg_value;

    int n_chk = 0;
    int n_bad = 0;
    int n_evt = 0;
    int trig_cyc = 0;
    int n_rstp = 0;
    logic [M-1:0] trig_seen = '0;
    logic [IW-1:0] exp_q[$];
    logic [31:0] rd;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_router #(.N_MST(M), .N_CH(C)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_trig(hw_trig),
        .mst_busy(mst_busy), .xfer_fin(xfer_fin), .proc_fin(proc_fin),
        .trig_out(trig_out), .core_rst(core_rst), .cont_mode(cont_mode),
        .spi_manual(spi_manual), .spi_timing(spi_timing), .cfg_we(cfg_we),
        .cfg_kind(cfg_kind), .cfg_mst(cfg_mst), .cfg_ch(cfg_ch),
        .cfg_value(cfg_value)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rdreg(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_clear(int bitpos);
        logic [31:0] v;
        for (int i = 0; i < 40; i++) begin
            rdreg(A_CTRL, v);
            if (!v[bitpos]) break;
        end
    endtask

    task automatic expect_cfg(logic [1:0] k, logic [M-1:0] mm, logic [C-1:0] cm, logic [31:0] v);
        exp_q.push_back({k, mm, cm, v});
    endtask

    task automatic clear_mon();
        @(negedge clk);
        trig_seen = '0; trig_cyc = 0;
    endtask

    // scoreboard monitor
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (core_rst) n_rstp++;
            if (trig_out != '0) begin
                trig_seen |= trig_out;
                trig_cyc++;
            end
            if (cfg_we) begin
                n_evt++;
                if (exp_q.size() == 0) begin
                    check("R3 unexpected strobe", 64'(cfg_value), 64'hDEAD);
                end else begin
                    check("R3 strobe contents", 64'({cfg_kind, cfg_mst, cfg_ch, cfg_value}),
                          64'(exp_q.pop_front()));
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        int ev0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rdreg(A_CTRL, rd);  check("R1 ctrl", rd, 0);
        rdreg(A_AVAIL, rd); check("R1 avail", rd, 32'hF);
        rdreg(A_MSEL, rd);  check("R1 msel", rd, 0);
        rdreg(A_VAL, rd);   check("R1 value", rd, 0);
        rdreg(A_STIM, rd);  check("R1 timing", rd, 0);
        check("R1 spi manual", spi_manual, 8'h40);
        check("R1 strobe/trig idle", {cfg_we, trig_out}, 0);

        // R2 read-back and width
        wr(A_MSEL, 32'hFFFF_FFFF); rdreg(A_MSEL, rd); check("R2 msel width", rd, 32'hF);
        wr(A_CSEL, 32'h0000_0181); rdreg(A_CSEL, rd); check("R2 csel width", rd, 32'h81);
        wr(A_STIM, 32'h1234_5678); rdreg(A_STIM, rd); check("R2 timing", rd, 32'h1234_5678);
        check("R2 timing port", spi_timing, 32'h1234_5678);

        // R3 / R5 each kind
        wr(A_MSEL, 32'h5);
        wr(A_VAL, 32'hFFFF_FF9C);
        expect_cfg(2'd0, 4'h5, 8'h81, 32'hFFFF_FF9C);
        wr(A_CTRL, 32'h10);
        wait_clear(4);
        rdreg(A_CTRL, rd); check("R5 valid cleared", rd[4], 0);
        check("R3 offset delivered", exp_q.size(), 0);
        wr(A_VAL, 32'h40);
        expect_cfg(2'd1, 4'h5, 8'h81, 32'h40);
        wr(A_CTRL, 32'h30); wait_clear(4);
        wr(A_VAL, 32'd7);
        expect_cfg(2'd2, 4'h5, 8'h81, 32'd7);
        wr(A_CTRL, 32'h50); wait_clear(4);
        wr(A_CSEL, 32'h02);
        wr(A_VAL, 32'd100);
        expect_cfg(2'd3, 4'h5, 8'h02, 32'd100);
        wr(A_CTRL, 32'h70); wait_clear(4);
        check("R3 all kinds delivered", exp_q.size(), 0);
        check("R3 strobe count", n_evt, 4);

        // R4 hold while a selected master is busy
        @(negedge clk); mst_busy = 4'b0100;
        expect_cfg(2'd0, 4'h5, 8'h02, 32'd100);
        wr(A_CTRL, 32'h10);
        repeat (8) @(negedge clk);
        rdreg(A_CTRL, rd); check("R4 valid held", rd[4], 1);
        check("R4 strobe held", exp_q.size(), 1);
        @(negedge clk); mst_busy = '0;
        wait_clear(4);
        check("R4 strobe after release", exp_q.size(), 0);
        // unselected busy does not delay
        @(negedge clk); mst_busy = 4'b1010;
        expect_cfg(2'd0, 4'h5, 8'h02, 32'd100);
        wr(A_CTRL, 32'h10);
        repeat (4) @(negedge clk);
        check("R4 unselected busy ignored", exp_q.size(), 0);
        @(negedge clk); mst_busy = '0;
        wait_clear(4);

        // R6 reserved selector
        ev0 = n_evt;
        wr(A_CTRL, 32'h90);
        wait_clear(4);
        rdreg(A_CTRL, rd); check("R6 reserved acknowledged", rd[4], 0);
        check("R6 reserved no strobe", n_evt, ev0);

        // R10 done flags set on finish
        @(negedge clk); xfer_fin = 4'hF; proc_fin = 4'h3;
        @(negedge clk); xfer_fin = '0; proc_fin = '0;
        rdreg(A_XDONE, rd); check("R10 xdone set", rd, 32'hF);
        rdreg(A_PDONE, rd); check("R10 pdone set", rd, 32'h3);

        // R7 software trigger, held by busy then fired together
        wr(A_MSEL, 32'h7);
        wr(A_AVAIL, 32'hD);
        clear_mon();
        @(negedge clk); mst_busy = 4'b0001;
        wr(A_CTRL, 32'h06);
        repeat (6) @(negedge clk);
        rdreg(A_CTRL, rd); check("R7 trigger held while busy", rd[2], 1);
        check("R7 no pulse while busy", trig_seen, 0);
        @(negedge clk); mst_busy = '0;
        wait_clear(2);
        repeat (2) @(negedge clk);
        check("R7 pulse mask", trig_seen, 4'h5);
        check("R7 single cycle", trig_cyc, 1);

        // R10 clear on start, read-only
        rdreg(A_XDONE, rd); check("R10 xdone cleared", rd, 32'hA);
        rdreg(A_PDONE, rd); check("R10 pdone cleared", rd, 32'h2);
        wr(A_XDONE, 32'h0);
        rdreg(A_XDONE, rd); check("R10 xdone read-only", rd, 32'hA);

        // R12 busy view
        @(negedge clk); mst_busy = 4'b1010;
        rdreg(A_BUSY, rd); check("R12 busy view", rd, 32'hA);
        @(negedge clk); mst_busy = '0;

        // R8 hardware source, master mask ignored
        wr(A_MSEL, 32'h1);
        wr(A_CTRL, 32'h00);
        @(negedge clk); hw_trig = 4'hF;
        #1 check("R8 hw trigger masked by avail", trig_out, 4'hD);
        @(negedge clk); mst_busy = 4'b0100;
        #1 check("R8 hw trigger masked by busy", trig_out, 4'h9);
        @(negedge clk); hw_trig = '0; mst_busy = '0;
        wr(A_CTRL, 32'h02);
        @(negedge clk); hw_trig = 4'hF;
        #1 check("R8 pins ignored with software source", trig_out, 4'h0);
        @(negedge clk); hw_trig = '0;
        wr(A_CTRL, 32'h00);
        clear_mon();
        wr(A_CTRL, 32'h04);
        wait_clear(2);
        rdreg(A_CTRL, rd); check("R8 sw bit cleared under hw source", rd[2], 0);
        check("R8 sw bit no pulse under hw source", trig_seen, 0);

        // R9 continuous
        wr(A_CTRL, 32'h01);
        @(negedge clk); mst_busy = 4'b0010;
        #1 check("R9 continuous ready", trig_out, 4'hD);
        check("R9 mode port", cont_mode, 1);
        @(negedge clk); mst_busy = 4'b0100;
        #1 check("R9 continuous busy", trig_out, 4'h9);
        @(negedge clk); mst_busy = '0;

        // R11 software reset
        wr(A_VAL, 32'h55);
        n_rstp = 0;
        wr(A_CTRL, 32'h09);
        repeat (2) @(negedge clk);
        check("R11 one reset pulse", n_rstp, 1);
        rdreg(A_CTRL, rd);  check("R11 ctrl default", rd, 0);
        rdreg(A_AVAIL, rd); check("R11 avail default", rd, 32'hF);
        rdreg(A_MSEL, rd);  check("R11 msel default", rd, 0);
        rdreg(A_VAL, rd);   check("R11 value default", rd, 0);
        rdreg(A_STIM, rd);  check("R11 timing default", rd, 0);
        rdreg(A_XDONE, rd); check("R11 xdone default", rd, 0);
        check("R11 spi manual default", spi_manual, 8'h40);

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule